// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block holds two address pointers for an 8-bit processor core. One of them is active at any time and drives the memory address output. The core sends one event pulse for each pointer-related instruction it executes: an explicit pointer increment, a load of an immediate pointer value, a table read through the pointer, an external memory read and an external memory write. The unit updates the active pointer for each event. A control register sets three things: which pointer is active, whether the selection flips automatically after each pointer instruction, and whether the three memory-access instructions step the active pointer afterwards. Each pointer has its own direction bit that makes it count up or down.

Software writes the pointer bytes and the control register through byte-wide write strobes. The core then uses `addr_o` as the address for table and external accesses. With the toggle option, two pointers can serve as source and destination of a block copy without any select writes between the accesses. With auto-step, the pointers walk through memory by themselves.

Top module: `ddp_unit`

## Requirements
- R1: After reset both pointers hold 0000h, `ctl_o` reads 04h and `addr_o` is 0000h.
- R2: `addr_o` shows pointer 0 while control bit 0 (select) is 0, and pointer 1 while it is 1. A strobe bit b in `wr_ptr0_byte`/`wr_ptr1_byte` loads `wr_data` into byte b of that pointer (bit 0 is the low byte) and leaves the other byte as it was.
- R3: Control bits 3..1 always read 010b, whatever value is written to them. Bits 7, 6, 5, 4 and 0 read back as written.
- R4: `ev_load` stores `load_val` into the active pointer.
- R5: `ev_inc` steps the active pointer by one. Pointer 0 follows direction bit 6 and pointer 1 follows bit 7 (0 = up, 1 = down). The step wraps modulo 2^16.
- R6: When control bit 4 (auto-step) is set, `ev_table`, `ev_xrd` and `ev_xwr` step the active pointer in its direction. When bit 4 is clear, these events leave both pointers unchanged. `ev_load` never steps.
- R7: When control bit 5 (toggle) is set, any of the five events inverts the select bit one cycle later. When bit 5 is clear, the select bit does not change.
- R8: If one event both steps or loads a pointer and toggles the select bit, the update goes to the pointer that was active before the toggle.
- R9: A byte write strobe to a pointer in the same cycle as a load or step of that pointer wins. That pointer takes the byte write only.
- R10: A control register write in the same cycle as an event sets the control register to the written value and suppresses the toggle. The pointer update of the event still goes to the pointer that was active before the write.
- R11: An event changes only the active pointer. The inactive pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_ptr0_byte | input | PTR_W/8 | Byte write strobes for pointer 0 |
| wr_ptr1_byte | input | PTR_W/8 | Byte write strobes for pointer 1 |
| wr_ctl | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data byte |
| ev_inc | input | 1 | Pointer increment instruction executed |
| ev_load | input | 1 | Immediate pointer load executed |
| ev_table | input | 1 | Table read through pointer executed |
| ev_xrd | input | 1 | External read through pointer executed |
| ev_xwr | input | 1 | External write through pointer executed |
| load_val | input | PTR_W | Immediate value for `ev_load` |
| addr_o | output | PTR_W | Active pointer value |
| ctl_o | output | 8 | Control register read value |

## Verification
A wrong select bit shows on `addr_o` in the first cycle after the event that corrupted it, because the output mux is combinational from the registered state. A wrong value in the inactive pointer is hidden until the select bit reaches it, so every case reads both pointers back right after the event. The sweep goes through all five events, both direction bits, both option bits and both select values, with pointers at the wrap boundaries. The bench also drives collisions between writes and events, where a priority error leaves one wrong byte or one wrong select bit.

// File: rtl/ddp_pkg.sv
package ddp_pkg;

   // control register bit positions
   localparam int SEL_BIT  = 0;
   localparam int AUTO_BIT = 4;
   localparam int TGL_BIT  = 5;
   localparam int DIR0_BIT = 6;
   localparam int DIR1_BIT = 7;

   localparam logic [2:0] RSVD_VAL = 3'b010;
   localparam int         NPTR     = 2;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_STEP = 2'd2
   } ptr_op_e;

   typedef struct packed {
      logic dir1;
      logic dir0;
      logic tgl;
      logic auto_en;
      logic sel;
   } ctl_fields_t;

endpackage

// File: rtl/ddp_ptr.sv
module ddp_ptr
   import ddp_pkg::*;
#(
   parameter int PTR_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [PTR_W/8-1:0]     byte_we,
   input  logic [7:0]             wr_data,
   input  ptr_op_e                op,
   input  logic                   step_down,
   input  logic [PTR_W-1:0]       load_val,
   output logic [PTR_W-1:0]       value_o
);

   localparam int NBYTE = PTR_W / 8;
   localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

   logic [PTR_W-1:0] cur_q;
   logic [PTR_W-1:0] patched;
   logic [PTR_W-1:0] stepped;
   logic [PTR_W-1:0] nxt;

   genvar b;
   generate
      for (b = 0; b < NBYTE; b++) begin : g_byte
         assign patched[8*b +: 8] = byte_we[b] ? wr_data : cur_q[8*b +: 8];
      end
   endgenerate

   assign stepped = step_down ? (cur_q - ONE) : (cur_q + ONE);

   always_comb begin
      if (|byte_we) begin
         nxt = patched;
      end else begin
         unique case (op)
            OP_LOAD: nxt = load_val;
            OP_STEP: nxt = stepped;
            default: nxt = cur_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= '0;
      else        cur_q <= nxt;
   end

   assign value_o = cur_q;

endmodule

// File: rtl/ddp_ctl.sv
module ddp_ctl
   import ddp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  ctl_fields_t wr_fields,
   input  logic        toggle_ev,
   output ctl_fields_t fields_o,
   output logic [7:0]  ctl_o
);

   ctl_fields_t f_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_q <= '0;
      end else if (wr_en) begin
         f_q <= wr_fields;
      end else if (f_q.tgl && toggle_ev) begin
         f_q.sel <= ~f_q.sel;
      end
   end

   always_comb begin
      ctl_o           = '0;
      ctl_o[DIR1_BIT] = f_q.dir1;
      ctl_o[DIR0_BIT] = f_q.dir0;
      ctl_o[TGL_BIT]  = f_q.tgl;
      ctl_o[AUTO_BIT] = f_q.auto_en;
      ctl_o[3:1]      = RSVD_VAL;
      ctl_o[SEL_BIT]  = f_q.sel;
   end

   assign fields_o = f_q;

endmodule

// File: rtl/ddp_unit.sv
module ddp_unit
   import ddp_pkg::*;
#(
   parameter int PTR_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PTR_W/8-1:0]   wr_ptr0_byte,
   input  logic [PTR_W/8-1:0]   wr_ptr1_byte,
   input  logic                 wr_ctl,
   input  logic [7:0]           wr_data,
   input  logic                 ev_inc,
   input  logic                 ev_load,
   input  logic                 ev_table,
   input  logic                 ev_xrd,
   input  logic                 ev_xwr,
   input  logic [PTR_W-1:0]     load_val,
   output logic [PTR_W-1:0]     addr_o,
   output logic [7:0]           ctl_o
);

   localparam int NBYTE = PTR_W / 8;

   generate
      if (PTR_W < 8 || (PTR_W % 8) != 0) begin : g_bad_width
         $error("ddp_unit: PTR_W must be a nonzero multiple of 8");
      end
   endgenerate

   ctl_fields_t fields;
   ctl_fields_t wr_fields;
   logic        access_ev;
   logic        any_ev;
   logic        step_req;

   logic [NBYTE-1:0] ptr_we  [NPTR];
   logic [PTR_W-1:0] ptr_val [NPTR];
   ptr_op_e          ptr_op  [NPTR];
   logic             ptr_dn  [NPTR];

   assign wr_fields = '{dir1:    wr_data[DIR1_BIT],
                        dir0:    wr_data[DIR0_BIT],
                        tgl:     wr_data[TGL_BIT],
                        auto_en: wr_data[AUTO_BIT],
                        sel:     wr_data[SEL_BIT]};

   assign access_ev = ev_table | ev_xrd | ev_xwr;
   assign any_ev    = access_ev | ev_inc | ev_load;
   assign step_req  = ev_inc | (fields.auto_en & access_ev);

   assign ptr_we[0] = wr_ptr0_byte;
   assign ptr_we[1] = wr_ptr1_byte;
   assign ptr_dn[0] = fields.dir0;
   assign ptr_dn[1] = fields.dir1;

   ddp_ctl ctl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_ctl),
      .wr_fields (wr_fields),
      .toggle_ev (any_ev),
      .fields_o  (fields),
      .ctl_o     (ctl_o)
   );

   genvar p;
   generate
      for (p = 0; p < NPTR; p++) begin : g_ptr
         logic active;
         assign active = (fields.sel == p[0]);

         always_comb begin
            if (!active)       ptr_op[p] = OP_HOLD;
            else if (ev_load)  ptr_op[p] = OP_LOAD;
            else if (step_req) ptr_op[p] = OP_STEP;
            else               ptr_op[p] = OP_HOLD;
         end

         ddp_ptr #(.PTR_W(PTR_W)) ptr_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .byte_we   (ptr_we[p]),
            .wr_data   (wr_data),
            .op        (ptr_op[p]),
            .step_down (ptr_dn[p]),
            .load_val  (load_val),
            .value_o   (ptr_val[p])
         );
      end
   endgenerate

   assign addr_o = fields.sel ? ptr_val[1] : ptr_val[0];

endmodule

// File: rtl/ddp_unit_chk.sv
module ddp_unit_chk #(
   parameter int PTR_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PTR_W/8-1:0] wr_ptr0_byte,
   input logic [PTR_W/8-1:0] wr_ptr1_byte,
   input logic               wr_ctl,
   input logic               ev_inc,
   input logic               ev_load,
   input logic               ev_table,
   input logic               ev_xrd,
   input logic               ev_xwr,
   input logic [PTR_W-1:0]   load_val,
   input logic [PTR_W-1:0]   addr_o,
   input logic [7:0]         ctl_o
);

   localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

   logic quiet;
   logic access;
   logic any_ev;
   logic act_dir;

   assign quiet   = ~|wr_ptr0_byte && ~|wr_ptr1_byte && !wr_ctl;
   assign access  = ev_table | ev_xrd | ev_xwr;
   assign any_ev  = access | ev_inc | ev_load;
   assign act_dir = ctl_o[0] ? ctl_o[7] : ctl_o[6];

   // R3
   rsvd_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o[3:1] == 3'b010);

   // R7
   toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o[5] && any_ev && !wr_ctl) |=> (ctl_o[0] != $past(ctl_o[0])));

   // R4
   load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_load && !ctl_o[5] && quiet) |=> (addr_o == $past(load_val)));

   // R5
   inc_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_inc && !ev_load && !ctl_o[5] && quiet && !act_dir)
      |=> (addr_o == $past(addr_o) + ONE));

   // R6
   no_auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !ev_inc && !ev_load && !ctl_o[4] && !ctl_o[5] && quiet)
      |=> $stable(addr_o));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_ev && quiet) |=> ($stable(addr_o) && $stable(ctl_o)));

endmodule

bind ddp_unit ddp_unit_chk #(.PTR_W(PTR_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_ptr0_byte (wr_ptr0_byte),
   .wr_ptr1_byte (wr_ptr1_byte),
   .wr_ctl       (wr_ctl),
   .ev_inc       (ev_inc),
   .ev_load      (ev_load),
   .ev_table     (ev_table),
   .ev_xrd       (ev_xrd),
   .ev_xwr       (ev_xwr),
   .load_val     (load_val),
   .addr_o       (addr_o),
   .ctl_o        (ctl_o)
);

// File: tb/ddp_unit_tb.sv
module ddp_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  wr_ptr0_byte;
   logic [1:0]  wr_ptr1_byte;
   logic        wr_ctl;
   logic [7:0]  wr_data;
   logic        ev_inc, ev_load, ev_table, ev_xrd, ev_xwr;
   logic [15:0] load_val;
   logic [15:0] addr_o;
   logic [7:0]  ctl_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   ddp_unit #(.PTR_W(16)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_ptr0_byte(wr_ptr0_byte), .wr_ptr1_byte(wr_ptr1_byte),
      .wr_ctl(wr_ctl), .wr_data(wr_data),
      .ev_inc(ev_inc), .ev_load(ev_load), .ev_table(ev_table),
      .ev_xrd(ev_xrd), .ev_xwr(ev_xwr), .load_val(load_val),
      .addr_o(addr_o), .ctl_o(ctl_o)
   );

   task automatic idle_all();
      wr_ptr0_byte = '0; wr_ptr1_byte = '0; wr_ctl = 1'b0; wr_data = '0;
      ev_inc = 0; ev_load = 0; ev_table = 0; ev_xrd = 0; ev_xwr = 0;
      load_val = '0;
   endtask

   task automatic step_clk();
      @(negedge clk);
      idle_all();
   endtask

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %04h expected %04h", req, act, exp);
      end
   endtask

   task automatic put_ctl(logic [7:0] v);
      wr_ctl = 1'b1; wr_data = v;
      step_clk();
   endtask

   task automatic put_ptr(int p, logic [15:0] v);
      for (int b = 0; b < 2; b++) begin
         if (p == 0) wr_ptr0_byte = 2'(1 << b);
         else        wr_ptr1_byte = 2'(1 << b);
         wr_data = v[8*b +: 8];
         step_clk();
      end
   endtask

   task automatic fire(int ev, logic [15:0] lv);
      case (ev)
         0: ev_inc   = 1'b1;
         1: ev_load  = 1'b1;
         2: ev_table = 1'b1;
         3: ev_xrd   = 1'b1;
         default: ev_xwr = 1'b1;
      endcase
      load_val = lv;
   endtask

   function automatic logic [15:0] pat(int i);
      case (i % 4)
         0: return 16'h0000;
         1: return 16'hFFFF;
         2: return 16'h12FF;
         default: return 16'h8000;
      endcase
   endfunction

   initial begin
      idle_all();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 ctl", {8'h00, ctl_o}, 16'h0004);
      chk("R1 addr", addr_o, 16'h0000);
      put_ctl(8'h01);
      chk("R1 ptr1", addr_o, 16'h0000);

      // R3: reserved bits ignore writes of 1s and 0s
      put_ctl(8'hFE);
      chk("R3 ones", {8'h00, ctl_o}, 16'h00F4);
      put_ctl(8'h01);
      chk("R3 zeros", {8'h00, ctl_o}, 16'h0005);

      // R2: byte strobes and select
      put_ctl(8'h00);
      wr_ptr0_byte = 2'b01; wr_data = 8'h3C; step_clk();
      chk("R2 low byte", addr_o, 16'h003C);
      wr_ptr0_byte = 2'b10; wr_data = 8'hA7; step_clk();
      chk("R2 high byte", addr_o, 16'hA73C);
      put_ptr(1, 16'h5E11);
      chk("R2 sel0", addr_o, 16'hA73C);
      put_ctl(8'h01);
      chk("R2 sel1", addr_o, 16'h5E11);

      // sweep: events x auto x toggle x dir0 x dir1 x sel
      for (int ev = 0; ev < 5; ev++) begin
         for (int cfg = 0; cfg < 32; cfg++) begin
            logic        au, tg, d0, d1, sl, dir, chg, nsel;
            logic [15:0] p0, p1, lv, cur, nv, e0, e1;
            logic [7:0]  cv;
            string       tag;
            au = cfg[0]; tg = cfg[1]; d0 = cfg[2]; d1 = cfg[3]; sl = cfg[4];
            p0 = pat(ev + cfg); p1 = pat(ev + cfg + 1);
            lv = 16'hC35A ^ 16'(cfg * 16'h0111);
            put_ctl(8'h00);
            put_ptr(0, p0);
            put_ptr(1, p1);
            cv = {d1, d0, tg, au, 3'b101, sl};
            put_ctl(cv);
            fire(ev, lv);
            step_clk();
            cur = sl ? p1 : p0;
            dir = sl ? d1 : d0;
            chg = (ev == 0) || (ev == 1) || au;
            if (ev == 1)  nv = lv;
            else if (chg) nv = dir ? cur - 16'd1 : cur + 16'd1;
            else          nv = cur;
            e0 = sl ? p0 : nv;
            e1 = sl ? nv : p1;
            nsel = sl ^ tg;
            if (tg)           tag = "R8";
            else if (ev == 1) tag = "R4";
            else if (ev == 0) tag = "R5";
            else              tag = "R6";
            chk("R7 ctl", {8'h00, ctl_o}, {8'h00, d1, d0, tg, au, 3'b010, nsel});
            chk(tag, addr_o, nsel ? e1 : e0);
            put_ctl(8'h00);
            chk(sl ? "R11 p0" : {tag, " p0"}, addr_o, e0);
            put_ctl(8'h01);
            chk(sl ? {tag, " p1"} : "R11 p1", addr_o, e1);
         end
      end

      // R9: byte write beats an auto-step on the same pointer
      put_ctl(8'h00);
      put_ptr(0, 16'h1234);
      put_ctl(8'h10);
      ev_table = 1'b1; wr_ptr0_byte = 2'b01; wr_data = 8'hAB; step_clk();
      chk("R9 step", addr_o, 16'h12AB);
      // R9: byte write beats a load
      ev_load = 1'b1; load_val = 16'h7777; wr_ptr0_byte = 2'b10; wr_data = 8'h9E;
      step_clk();
      chk("R9 load", addr_o, 16'h9EAB);

      // R10: control write beats toggle, step still hits the old pointer
      put_ptr(1, 16'h0F00);
      put_ctl(8'h21);
      ev_inc = 1'b1; wr_ctl = 1'b1; wr_data = 8'h01; step_clk();
      chk("R10 ctl", {8'h00, ctl_o}, 16'h0005);
      chk("R10 addr", addr_o, 16'h0F01);
      put_ctl(8'h00);
      chk("R10 other", addr_o, 16'h9EAB);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule